// File: doc/BRIEF.md
# Data Access Translator with Fault Status

This block turns the virtual address of a load or store into a physical address. It checks the address and applies a kernel-only superpage window. It then takes the result of an external translation buffer lookup and checks it against per-mode read and write enables and against fault-on-read and fault-on-write trap bits. A request is presented for one cycle. The block returns a registered response one cycle later. The response carries a result code, the physical address and two attribute flags taken from that address: uncacheable, and reads-as-zero for one fixed address inside the internal-register window.

When a request faults, the block captures three values: the faulting virtual address, a packed status word and a formatted page-table-entry address. It then locks these values. A later fault cannot overwrite them until the consumer signals that it has read the address register. The effective privilege mode normally comes from the current data mode. In firmware mode it is the alternate mode for requests flagged as alternate, and kernel for all other requests.

Top module: `dat_xlate`

## Requirements
- R1: Effective mode (2 bits, kernel = 0) equals `cur_mode` when `fw_mode` is 0. When `fw_mode` is 1 it equals `alt_mode` if `alt_req` is 1, and kernel otherwise. Permission checks index the enable masks with bit `1 << mode`.
- R2: A virtual address is bad when bits 63:43 do not all equal bit 42. The result is code TRAP (2) with status flags ACV and BADVA, plus WR for stores.
- R3: Status word bits 16:11 hold the 6-bit opcode and bits 10:6 hold the 5-bit destination register. Bits 5:0 hold the cause flags: WR = bit 0, ACV = bit 1, FONR = bit 2, FONW = bit 3, MISS = bit 4, BADVA = bit 5.
- R4: When `sp_en` is 1 and address bits 42:41 equal 2, the physical address is the low 40 bits of the address. This requires `cur_mode` to be kernel. Any other mode gives code ACV (1) with flags ACV, plus WR for stores.
- R5: A miss gives code MISS (3), or PTE_MISS (4) when `vpte_req` is 1. Its flags are MISS, plus WR for stores.
- R6: On a hit the physical address is the frame number concatenated with address bits 12:0. A store whose write enable for the effective mode is clear gives TRAP with WR and ACV, plus FONW if that bit is set. Otherwise a set FONW bit gives TRAP with only WR and FONW.
- R7: For a load with a clear read enable, the result is ACV with flag ACV, plus FONR if that bit is set. Otherwise a set FONR bit gives TRAP with only FONR. A load that passes gives OK (0).
- R8: On success, `rsp_uncached` is 1 when physical bit 39 is set, unless bits 39:32 are all ones (the internal-register window). `rsp_zero` is 1 only for physical address 0xFF_FFF0_0188.
- R9: A fault while unlocked captures the address and the status word. It also captures a formatted address equal to `pt_base` OR (address bits 42:13 shifted left by 3), and sets `fault_locked`.
- R10: While locked, further faults leave the captured registers unchanged. A `va_rd` pulse clears the lock.
- R11: The response arrives in the cycle after the request, and `rsp_valid` is 1 only for that one cycle. Reset clears the lock and all captured registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | Store when 1 |
| req_alt | input | 1 | Request uses the alternate mode |
| req_vpte | input | 1 | Request is a page-table-entry fetch |
| req_opcode | input | 6 | Opcode recorded on fault |
| req_dest | input | 5 | Destination register recorded on fault |
| fw_mode | input | 1 | Firmware mode active |
| cur_mode | input | 2 | Current data mode |
| alt_mode | input | 2 | Alternate mode |
| sp_en | input | 1 | Superpage window enable |
| pt_base | input | 64 | Page-table base for formatted address |
| tb_vpn | output | 30 | Page number sent to the external translation buffer |
| tb_hit | input | 1 | Translation buffer hit |
| tb_pfn | input | 27 | Page frame number |
| tb_rd_en | input | 4 | Read enable per mode |
| tb_wr_en | input | 4 | Write enable per mode |
| tb_fonr | input | 1 | Fault-on-read bit |
| tb_fonw | input | 1 | Fault-on-write bit |
| va_rd | input | 1 | Address register read; clears lock |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 3 | Result code |
| rsp_pa | output | 40 | Physical address |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_zero | output | 1 | Access reads as zero |
| fault_va | output | 64 | Captured faulting address |
| fault_stat | output | 17 | Captured status word |
| fault_form | output | 64 | Captured formatted address |
| fault_locked | output | 1 | Fault registers locked |

## Verification
On every cycle, the assertions check four things about the captured registers. The lock holds them stable until a read. A reported fault always leaves the lock set unless a read happened in the same cycle. A fresh capture carries the opcode, destination register and address of the request that faulted, with at least one cause flag set. An uncacheable or zero-read response never comes with a fault code. Only the bench scenarios can show the full decision order. The bench sweeps every combination of firmware mode, alternate request, both mode registers, access type, enable mask and trap bit. The same holds for the exact cause-flag sets, the miss-code split for page-table fetches, superpage handling and the single zero-read address.

// File: rtl/dat_pkg.sv
// Shared codes and cause-flag positions for the data access translator.
package dat_pkg;
    typedef enum logic [2:0] {
        XL_OK       = 3'd0,
        XL_ACV      = 3'd1,
        XL_TRAP     = 3'd2,
        XL_MISS     = 3'd3,
        XL_PTE_MISS = 3'd4
    } xl_code_e;

    localparam int FL_WR    = 0;
    localparam int FL_ACV   = 1;
    localparam int FL_FONR  = 2;
    localparam int FL_FONW  = 3;
    localparam int FL_MISS  = 4;
    localparam int FL_BADVA = 5;
    localparam int FLAG_W   = 6;

    localparam logic [1:0] MODE_KERNEL = 2'd0;
endpackage

// File: rtl/dat_mode_sel.sv
// Picks the effective privilege mode for a data access.
// Assumes kernel is encoded as 0 and that firmware mode is a single flag.
module dat_mode_sel (
    input  logic       fw_mode,
    input  logic       alt_req,
    input  logic [1:0] cur_mode,
    input  logic [1:0] alt_mode,
    output logic [1:0] eff_mode
);
    import dat_pkg::*;

    // Firmware mode overrides the current mode with alternate or kernel.
    always_comb begin
        if (fw_mode) eff_mode = alt_req ? alt_mode : MODE_KERNEL;
        else         eff_mode = cur_mode;
    end
endmodule

// File: rtl/dat_classify.sv
// Combinational fault classification and physical address forming.
// Assumes the translation buffer result is valid in the same cycle as the address.
module dat_classify #(
    parameter int VA_W    = 64,
    parameter int VA_IMPL = 43,
    parameter int PA_W    = 40,
    parameter int PG_BITS = 13
) (
    input  logic [VA_W-1:0]         va,
    input  logic                    is_write,
    input  logic                    vpte_req,
    input  logic [1:0]              eff_mode,
    input  logic [1:0]              cur_mode,
    input  logic                    sp_en,
    input  logic                    hit,
    input  logic [PA_W-PG_BITS-1:0] pfn,
    input  logic [3:0]              rd_en,
    input  logic [3:0]              wr_en,
    input  logic                    fonr,
    input  logic                    fonw,
    output dat_pkg::xl_code_e       code,
    output logic [dat_pkg::FLAG_W-1:0] flags,
    output logic [PA_W-1:0]         pa
);
    import dat_pkg::*;

    localparam int EXT_W = VA_W - VA_IMPL;

    logic bad_va;
    logic in_sp;
    logic [3:0] mode_bit;

    // Upper bits must replicate the top implemented bit.
    always_comb bad_va = (va[VA_W-1:VA_IMPL] != {EXT_W{va[VA_IMPL-1]}});

    // Superpage window: enabled and region bits equal 2.
    always_comb in_sp = sp_en && (va[VA_IMPL-1:VA_IMPL-2] == 2'b10);

    // One-hot mask bit for the effective mode.
    always_comb mode_bit = 4'b0001 << eff_mode;

    // Priority ordered classification.
    always_comb begin
        code  = XL_OK;
        flags = '0;
        pa    = {pfn, va[PG_BITS-1:0]};
        if (bad_va) begin
            code             = XL_TRAP;
            flags[FL_BADVA]  = 1'b1;
            flags[FL_ACV]    = 1'b1;
            flags[FL_WR]     = is_write;
        end else if (in_sp) begin
            pa = va[PA_W-1:0];
            if (cur_mode != MODE_KERNEL) begin
                code          = XL_ACV;
                flags[FL_ACV] = 1'b1;
                flags[FL_WR]  = is_write;
            end
        end else if (!hit) begin
            code           = vpte_req ? XL_PTE_MISS : XL_MISS;
            flags[FL_MISS] = 1'b1;
            flags[FL_WR]   = is_write;
        end else if (is_write) begin
            if ((wr_en & mode_bit) == 4'd0) begin
                code           = XL_TRAP;
                flags[FL_WR]   = 1'b1;
                flags[FL_ACV]  = 1'b1;
                flags[FL_FONW] = fonw;
            end else if (fonw) begin
                code           = XL_TRAP;
                flags[FL_WR]   = 1'b1;
                flags[FL_FONW] = 1'b1;
            end
        end else begin
            if ((rd_en & mode_bit) == 4'd0) begin
                code           = XL_ACV;
                flags[FL_ACV]  = 1'b1;
                flags[FL_FONR] = fonr;
            end else if (fonr) begin
                code           = XL_TRAP;
                flags[FL_FONR] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dat_fault_regs.sv
// Fault capture registers with a lock released by an address-register read.
// Assumes capture is a single-cycle pulse accompanying a faulting request.
module dat_fault_regs #(
    parameter int VA_W   = 64,
    parameter int STAT_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              va_rd,
    input  logic [VA_W-1:0]   in_va,
    input  logic [STAT_W-1:0] in_stat,
    input  logic [VA_W-1:0]   in_form,
    output logic [VA_W-1:0]   fault_va,
    output logic [STAT_W-1:0] fault_stat,
    output logic [VA_W-1:0]   fault_form,
    output logic              locked
);
    logic take;

    // Capture only while unlocked.
    always_comb take = capture && !locked;

    // Register update and lock bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_va   <= '0;
            fault_stat <= '0;
            fault_form <= '0;
            locked     <= 1'b0;
        end else begin
            if (take) begin
                fault_va   <= in_va;
                fault_stat <= in_stat;
                fault_form <= in_form;
            end
            locked <= (locked && !va_rd) || take;
        end
    end
endmodule

// File: rtl/dat_xlate.sv
// Data access translator top: mode selection, classification, fault capture
// and registered response. Assumes an external translation buffer answers
// combinationally to tb_vpn.
module dat_xlate #(
    parameter int VA_W      = 64,
    parameter int VA_IMPL   = 43,
    parameter int PA_W      = 40,
    parameter int PG_BITS   = 13,
    parameter int WIN_BITS  = 8,
    parameter logic [PA_W-1:0] ZERO_ADDR = 40'hFF_FFF0_0188,
    localparam int VPN_W    = VA_IMPL - PG_BITS,
    localparam int PFN_W    = PA_W - PG_BITS,
    localparam int STAT_W   = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic              req_alt,
    input  logic              req_vpte,
    input  logic [5:0]        req_opcode,
    input  logic [4:0]        req_dest,
    input  logic              fw_mode,
    input  logic [1:0]        cur_mode,
    input  logic [1:0]        alt_mode,
    input  logic              sp_en,
    input  logic [VA_W-1:0]   pt_base,
    output logic [VPN_W-1:0]  tb_vpn,
    input  logic              tb_hit,
    input  logic [PFN_W-1:0]  tb_pfn,
    input  logic [3:0]        tb_rd_en,
    input  logic [3:0]        tb_wr_en,
    input  logic              tb_fonr,
    input  logic              tb_fonw,
    input  logic              va_rd,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_uncached,
    output logic              rsp_zero,
    output logic [VA_W-1:0]   fault_va,
    output logic [STAT_W-1:0] fault_stat,
    output logic [VA_W-1:0]   fault_form,
    output logic              fault_locked
);
    import dat_pkg::*;

    logic [1:0]        eff_mode;
    xl_code_e          code;
    logic [FLAG_W-1:0] flags;
    logic [PA_W-1:0]   pa;
    logic [STAT_W-1:0] stat;
    logic [VA_W-1:0]   form;
    logic              is_fault;
    logic              in_win;

    // Page number for the external lookup.
    always_comb tb_vpn = req_va[VA_IMPL-1:PG_BITS];

    dat_mode_sel u_mode (
        .fw_mode  (fw_mode),
        .alt_req  (req_alt),
        .cur_mode (cur_mode),
        .alt_mode (alt_mode),
        .eff_mode (eff_mode)
    );

    dat_classify #(
        .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W), .PG_BITS(PG_BITS)
    ) u_cls (
        .va       (req_va),
        .is_write (req_write),
        .vpte_req (req_vpte),
        .eff_mode (eff_mode),
        .cur_mode (cur_mode),
        .sp_en    (sp_en),
        .hit      (tb_hit),
        .pfn      (tb_pfn),
        .rd_en    (tb_rd_en),
        .wr_en    (tb_wr_en),
        .fonr     (tb_fonr),
        .fonw     (tb_fonw),
        .code     (code),
        .flags    (flags),
        .pa       (pa)
    );

    // Pack status word and formatted table-entry address.
    always_comb begin
        stat     = {req_opcode, req_dest, flags};
        form     = pt_base | (VA_W'(tb_vpn) << 3);
        is_fault = (code != XL_OK);
        in_win   = (pa[PA_W-1 -: WIN_BITS] == {WIN_BITS{1'b1}});
    end

    dat_fault_regs #(.VA_W(VA_W), .STAT_W(STAT_W)) u_freg (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (req_valid && is_fault),
        .va_rd      (va_rd),
        .in_va      (req_va),
        .in_stat    (stat),
        .in_form    (form),
        .fault_va   (fault_va),
        .fault_stat (fault_stat),
        .fault_form (fault_form),
        .locked     (fault_locked)
    );

    // Registered response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_code     <= '0;
            rsp_pa       <= '0;
            rsp_uncached <= 1'b0;
            rsp_zero     <= 1'b0;
        end else begin
            rsp_valid    <= req_valid;
            rsp_code     <= code;
            rsp_pa       <= pa;
            rsp_uncached <= req_valid && !is_fault && pa[PA_W-1] && !in_win;
            rsp_zero     <= req_valid && !is_fault && (pa == ZERO_ADDR);
        end
    end
endmodule

// File: rtl/dat_xlate_chk.sv
// Property checker for dat_xlate, attached through bind.
module dat_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [63:0] req_va,
    input logic [5:0]  req_opcode,
    input logic [4:0]  req_dest,
    input logic        va_rd,
    input logic        rsp_valid,
    input logic [2:0]  rsp_code,
    input logic        rsp_uncached,
    input logic        rsp_zero,
    input logic [63:0] fault_va,
    input logic [16:0] fault_stat,
    input logic        fault_locked
);
    a_r10_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_locked && !va_rd) |=> ($stable(fault_va) && $stable(fault_stat)));

    a_r9_lock_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !va_rd) |=> ((rsp_code == 3'd0) || fault_locked));

    a_r3_stat_fields: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_locked) |-> (fault_stat[16:11] == $past(req_opcode)
                                 && fault_stat[10:6] == $past(req_dest)
                                 && fault_stat[5:0] != 6'd0));

    a_r9_va_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_locked) |-> (fault_va == $past(req_va)));

    a_r8_attr_ok_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_uncached || rsp_zero) |-> (rsp_valid && rsp_code == 3'd0));

    a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
endmodule

bind dat_xlate dat_xlate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_va       (req_va),
    .req_opcode   (req_opcode),
    .req_dest     (req_dest),
    .va_rd        (va_rd),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .rsp_uncached (rsp_uncached),
    .rsp_zero     (rsp_zero),
    .fault_va     (fault_va),
    .fault_stat   (fault_stat),
    .fault_locked (fault_locked)
);

// File: tb/dat_xlate_tb_top.sv
module dat_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic        req_write = 1'b0, req_alt = 1'b0, req_vpte = 1'b0;
    logic [5:0]  req_opcode = '0;
    logic [4:0]  req_dest = '0;
    logic        fw_mode = 1'b0;
    logic [1:0]  cur_mode = '0, alt_mode = '0;
    logic        sp_en = 1'b0;
    logic [63:0] pt_base = 64'h0000_0002_0000_0000;
    logic [29:0] tb_vpn;
    logic        tb_hit = 1'b0;
    logic [26:0] tb_pfn = '0;
    logic [3:0]  tb_rd_en = '0, tb_wr_en = '0;
    logic        tb_fonr = 1'b0, tb_fonw = 1'b0;
    logic        va_rd = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_code;
    logic [39:0] rsp_pa;
    logic        rsp_uncached, rsp_zero;
    logic [63:0] fault_va, fault_form;
    logic [16:0] fault_stat;
    logic        fault_locked;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dat_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_alt(req_alt), .req_vpte(req_vpte),
        .req_opcode(req_opcode), .req_dest(req_dest), .fw_mode(fw_mode),
        .cur_mode(cur_mode), .alt_mode(alt_mode), .sp_en(sp_en),
        .pt_base(pt_base), .tb_vpn(tb_vpn), .tb_hit(tb_hit), .tb_pfn(tb_pfn),
        .tb_rd_en(tb_rd_en), .tb_wr_en(tb_wr_en), .tb_fonr(tb_fonr),
        .tb_fonw(tb_fonw), .va_rd(va_rd), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached),
        .rsp_zero(rsp_zero), .fault_va(fault_va), .fault_stat(fault_stat),
        .fault_form(fault_form), .fault_locked(fault_locked)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one request; returns after the response edge, at a falling edge.
    task automatic issue();
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic release_lock();
        va_rd = 1'b1;
        @(negedge clk);
        va_rd = 1'b0;
    endtask

    // Independent reference: expected code and cause flags.
    function automatic void model(output logic [2:0] ecode, output logic [5:0] efl);
        logic [1:0] em;
        bit badv, spw;
        em = fw_mode ? (req_alt ? alt_mode : 2'd0) : cur_mode;
        badv = (req_va[63:43] != {21{req_va[42]}});
        spw = sp_en && req_va[42:41] == 2'd2;
        ecode = 3'd0; efl = 6'd0;
        if (badv) begin ecode = 3'd2; efl = 6'b100010 | {5'd0, req_write}; end
        else if (spw) begin
            if (cur_mode != 2'd0) begin ecode = 3'd1; efl = 6'b000010 | {5'd0, req_write}; end
        end else if (!tb_hit) begin
            ecode = req_vpte ? 3'd4 : 3'd3; efl = 6'b010000 | {5'd0, req_write};
        end else if (req_write) begin
            if (!tb_wr_en[em]) begin ecode = 3'd2; efl = 6'b000011 | {2'd0, tb_fonw, 3'd0}; end
            else if (tb_fonw) begin ecode = 3'd2; efl = 6'b001001; end
        end else begin
            if (!tb_rd_en[em]) begin ecode = 3'd1; efl = 6'b000010 | {3'd0, tb_fonr, 2'd0}; end
            else if (tb_fonr) begin ecode = 3'd2; efl = 6'b000100; end
        end
    endfunction

    task automatic run_check(input string req);
        logic [2:0] ec;
        logic [5:0] ef;
        logic [63:0] eform;
        bit locked_before;
        locked_before = fault_locked;
        model(ec, ef);
        eform = pt_base | ({34'd0, req_va[42:13]} << 3);
        issue();
        chk(rsp_valid == 1'b1, "R11 rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_code == ec, req, 64'(rsp_code), 64'(ec));
        if (ec != 3'd0 && !locked_before) begin
            chk(fault_stat == {req_opcode, req_dest, ef}, "R3 status word", 64'(fault_stat), 64'({req_opcode, req_dest, ef}));
            chk(fault_va == req_va, "R9 fault va", fault_va, req_va);
            chk(fault_form == eform, "R9 formatted address", fault_form, eform);
            chk(fault_locked == 1'b1, "R9 lock set", 64'(fault_locked), 64'd1);
            release_lock();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(rsp_valid == 1'b0, "R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk(fault_locked == 1'b0, "R11 reset lock", 64'(fault_locked), 64'd0);
        chk(fault_va == 64'd0, "R11 reset fault_va", fault_va, 64'd0);

        // R1 R6 R7: sweep of mode selection, permissions and trap bits on hits
        tb_hit = 1'b1;
        for (int fw = 0; fw < 2; fw++)
        for (int ar = 0; ar < 2; ar++)
        for (int cm = 0; cm < 4; cm++)
        for (int am = 0; am < 4; am++)
        for (int wr = 0; wr < 2; wr++)
        for (int en = 0; en < 16; en++)
        for (int fo = 0; fo < 2; fo++) begin
            fw_mode = fw[0]; req_alt = ar[0]; cur_mode = cm[1:0]; alt_mode = am[1:0];
            req_write = wr[0]; tb_rd_en = en[3:0]; tb_wr_en = en[3:0];
            tb_fonr = fo[0]; tb_fonw = fo[0];
            req_opcode = 6'(en + 3 * cm); req_dest = 5'(am + 7 * fo);
            tb_pfn = en[0] ? 27'h4000123 : 27'h0000456;
            req_va = 64'h0000_0123_4567_8000 | 64'(en * 8192 + fo * 17);
            run_check(wr[0] ? "R1/R6 store permission" : "R1/R7 load permission");
            if (rsp_code == 3'd0) begin
                chk(rsp_pa == {tb_pfn, req_va[12:0]}, "R6 hit physical address", 64'(rsp_pa), 64'({tb_pfn, req_va[12:0]}));
                chk(rsp_uncached == tb_pfn[26], "R8 uncached bit 39", 64'(rsp_uncached), 64'(tb_pfn[26]));
            end
        end
        fw_mode = 1'b0; req_alt = 1'b0; tb_fonr = 1'b0; tb_fonw = 1'b0;

        // R5: miss codes, ordinary and table-entry fetch, load and store
        tb_hit = 1'b0;
        for (int v = 0; v < 2; v++)
        for (int wr = 0; wr < 2; wr++) begin
            req_vpte = v[0]; req_write = wr[0];
            req_va = 64'h0000_0000_00AB_C000 + 64'(v * 4096 + wr);
            run_check("R5 miss code");
        end
        req_vpte = 1'b0;

        // R2: bad addresses at both sign-extension edges
        for (int k = 0; k < 4; k++) begin
            req_write = k[0];
            req_va = k[1] ? 64'h0000_0400_0000_0000 : 64'hFFFF_F800_0000_0000 | 64'h8000_0000_0000_0000;
            if (k[1]) req_va = 64'h0000_0400_0000_0000; else req_va = 64'h7FFF_FC00_0000_0000;
            run_check("R2 bad address");
        end

        // R4 R8: superpage, kernel and non-kernel, plus zero-read address
        sp_en = 1'b1; tb_hit = 1'b0; req_write = 1'b0;
        for (int cm = 0; cm < 4; cm++) begin
            cur_mode = cm[1:0];
            req_va = {21'h1FFFFF, 2'b10, 1'b0, 40'hFF_FFF0_0188};
            run_check("R4 superpage");
            if (cm == 0) begin
                chk(rsp_pa == 40'hFF_FFF0_0188, "R4 superpage pa", 64'(rsp_pa), 64'hFF_FFF0_0188);
                chk(rsp_zero == 1'b1, "R8 zero address", 64'(rsp_zero), 64'd1);
                chk(rsp_uncached == 1'b0, "R8 window not uncached", 64'(rsp_uncached), 64'd0);
            end
        end
        cur_mode = 2'd0;
        req_va = {21'h1FFFFF, 2'b10, 1'b0, 40'hFF_FFF0_0190};
        run_check("R8 near zero address");
        chk(rsp_zero == 1'b0, "R8 other window address", 64'(rsp_zero), 64'd0);
        req_va = {21'h1FFFFF, 2'b10, 1'b0, 40'h80_0000_1000};
        run_check("R8 uncached superpage");
        chk(rsp_uncached == 1'b1, "R8 uncached outside window", 64'(rsp_uncached), 64'd1);
        sp_en = 1'b0;

        // R10: lock holds first fault against a second one
        tb_hit = 1'b0; req_opcode = 6'h2A; req_dest = 5'h11;
        req_va = 64'h0000_0000_0001_2000;
        issue();
        req_opcode = 6'h05; req_dest = 5'h03;
        req_va = 64'h0000_0000_0009_9000;
        issue();
        chk(fault_va == 64'h0000_0000_0001_2000, "R10 locked va held", fault_va, 64'h12000);
        chk(fault_stat[16:6] == {6'h2A, 5'h11}, "R10 locked status held", 64'(fault_stat[16:6]), 64'({6'h2A, 5'h11}));
        release_lock();
        chk(fault_locked == 1'b0, "R10 read clears lock", 64'(fault_locked), 64'd0);
        issue();
        chk(fault_va == 64'h0000_0000_0009_9000, "R10 capture after release", fault_va, 64'h99000);
        release_lock();
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11 single-cycle response", 64'(rsp_valid), 64'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule